// File: doc/BRIEF.md
# SPI Flash User-Mode Transfer Engine

This block is a memory-mapped SPI flash master for up to three flash devices, each on its own chip-select line. Software drives every transaction by hand. It brings a device's chip select low by putting that device's control word into user mode with the stop flag cleared. It then pushes the opcode, the address bytes (most significant first, three or four of them) and any dummy zero bytes through the device's byte window. Before the data phase it may widen the data lines to two or four. It reads or writes the payload through the same window, and it ends the transaction by setting the stop flag again.

Each window access moves exactly one byte over the serial bus. The serial clock idles low, output bits change while the clock is low, and input bits are sampled on its rising edge (SPI mode 0). Bits go most significant first in every width. The request channel is valid/ready. The requester raises `req_valid` and holds address, direction and write data steady until it sees `req_ready` high at a clock edge. Register accesses and accesses to a window whose device is not in an active user-mode transaction are accepted in the cycle they are presented. An access to an active window holds `req_ready` low until the byte has fully crossed the bus. In the accepting cycle `rsp_rdata` carries the read result. The control word of the device being used must not be rewritten while one of its window accesses is in progress.

Top module: `spi_user_engine`

## Requirements
- R1: While reset is held and after it is released, every `spi_cs_n` line is high, `spi_sclk` is low, `spi_io_oe` is 0, each control word reads 0x00000004 (mode 00, stop 1), and the address-width register reads 0.
- R2: The control word of device i sits at byte offset 0x10 + 4·i. It stores a mode field in bits [1:0] (11 user, 01 command read, 10 command write, 00 normal), the stop flag in bit 2, a two-line data flag in bit 29 and a four-line data flag in bit 30; all other bits read 0. The address-width register at 0x04 stores one four-byte flag per device in bits [NCS-1:0]; other bits read 0.
- R3: `spi_cs_n[i]` is low exactly when control word i has mode 11 and the stop flag 0; setting the stop flag, or choosing any other mode, drives it high.
- R4: A write to the window of an active device (offset 0x40 + 4·i) is accepted only after the whole byte `req_wdata[7:0]` has been shifted out; `req_ready` goes high 2·HALF_DIV·(8/lanes) + 1 clock cycles after the request is first presented.
- R5: One window access produces 8/lanes rising edges of `spi_sclk`, each clock phase lasting HALF_DIV system cycles; the clock is low when idle and the driven data is stable while it is high.
- R6: With both width flags 0, a write drives its bits MSB first on IO0 with `spi_io_oe` = 0001, and a read samples IO1.
- R7: With bit 29 set, data moves two bits per clock on IO1:IO0 (IO1 the higher bit); with bit 30 set, four bits per clock on IO3:IO0 (IO3 highest); when both are set four lines are used. Writes enable exactly the lines in use (0011 or 1111).
- R8: A window read leaves `spi_io_oe` at 0 and returns the sampled byte in `rsp_rdata[7:0]`, with the upper bits zero, in the accepting cycle.
- R9: A window access to a device that is not in an active user-mode transaction is accepted in the cycle presented, produces no serial clock edge, and a read of it returns 0.
- R10: The width flags may be rewritten between bytes of one transaction with the stop flag kept 0; the chip select stays low and the next byte uses the new width.
- R11: Register accesses are accepted in the cycle presented, and a read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access accepted at this clock edge |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte offset of the register or window |
| req_wdata | input | 32 | Write data; windows use bits [7:0] |
| rsp_rdata | output | 32 | Read data, valid while `req_ready` is high |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | NCS | Active-low chip selects |
| spi_io_out | output | 4 | Serial data out, IO3..IO0 |
| spi_io_oe | output | 4 | Output enable per data line |
| spi_io_in | input | 4 | Serial data in, IO3..IO0 |

## Verification
All 256 byte values are written and then read through one window under each width setting: single, dual, quad, and both flags set. This tells apart bit-order mistakes, swapped lanes, a wrong lane priority and a wrong step count, because every bit position sees both a 0 and a 1 on every lane. The read pattern is the written value XOR 0x5A, so a read that merely echoes the last write is caught. Control words are tried with every mode code and with the stop flag on and off, which separates correct chip-select gating from stop-only or mode-only decoding. Window accesses to stopped or non-user devices show whether they are truly ignored on the bus. A width change in the middle of one transaction checks that the chip select survives it.

// File: rtl/spiu_pkg.sv
package spiu_pkg;

  typedef enum logic [1:0] {
    LANE1 = 2'd0,
    LANE2 = 2'd1,
    LANE4 = 2'd2
  } lane_e;

  typedef enum logic [1:0] {
    MD_NORMAL = 2'b00,
    MD_CMDRD  = 2'b01,
    MD_CMDWR  = 2'b10,
    MD_USER   = 2'b11
  } mode_e;

  typedef struct packed {
    logic  quad;
    logic  dual;
    logic  stop;
    mode_e mode;
  } ctrl_t;

  localparam int STOP_BIT = 2;
  localparam int DUAL_BIT = 29;
  localparam int QUAD_BIT = 30;

  localparam ctrl_t CTRL_RESET = '{quad: 1'b0, dual: 1'b0, stop: 1'b1, mode: MD_NORMAL};

  // Four lines win over two when both flags are set.
  function automatic lane_e lanes_of(ctrl_t c);
    if (c.quad)      return LANE4;
    else if (c.dual) return LANE2;
    else             return LANE1;
  endfunction

  function automatic logic [3:0] steps_of(lane_e l);
    case (l)
      LANE4:   return 4'd2;
      LANE2:   return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [31:0] ctrl_word(ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[1:0]     = c.mode;
    w[STOP_BIT] = c.stop;
    w[DUAL_BIT] = c.dual;
    w[QUAD_BIT] = c.quad;
    return w;
  endfunction

  function automatic ctrl_t ctrl_from(logic [31:0] w);
    ctrl_t c;
    c.mode = mode_e'(w[1:0]);
    c.stop = w[STOP_BIT];
    c.dual = w[DUAL_BIT];
    c.quad = w[QUAD_BIT];
    return c;
  endfunction

endpackage

// File: rtl/spiu_regs.sv
module spiu_regs #(
  parameter int NCS    = 3,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  output spiu_pkg::lane_e     lanes [NCS],
  output logic [NCS-1:0]      cs_n
);
  import spiu_pkg::*;

  localparam logic [ADDR_W-1:0] AW_OFS    = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] CTRL_BASE = ADDR_W'(16);

  ctrl_t          ctrl_q [NCS];
  logic [NCS-1:0] wide_addr_q;

  logic unused_wdata;
  assign unused_wdata = ^{wdata[31], wdata[28:3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_addr_q <= '0;
      for (int i = 0; i < NCS; i++) ctrl_q[i] <= CTRL_RESET;
    end else if (wr_en) begin
      if (addr == AW_OFS) wide_addr_q <= wdata[NCS-1:0];
      for (int i = 0; i < NCS; i++)
        if (addr == CTRL_BASE + ADDR_W'(4 * i)) ctrl_q[i] <= ctrl_from(wdata);
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW_OFS) rdata[NCS-1:0] = wide_addr_q;
    for (int i = 0; i < NCS; i++)
      if (addr == CTRL_BASE + ADDR_W'(4 * i)) rdata = ctrl_word(ctrl_q[i]);
  end

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign lanes[g] = lanes_of(ctrl_q[g]);
    assign cs_n[g]  = !((ctrl_q[g].mode == MD_USER) && !ctrl_q[g].stop);

    // R3: writing a control word with the stop flag set releases that select.
    a_r3_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == CTRL_BASE + ADDR_W'(4 * g) && wdata[STOP_BIT]) |=> cs_n[g]);

    // R3: a non-user mode code never leaves the select asserted.
    a_r3_mode_gates: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == CTRL_BASE + ADDR_W'(4 * g) && wdata[1:0] != 2'b11) |=> cs_n[g]);
  end

endmodule

// File: rtl/spiu_shifter.sv
module spiu_shifter #(
  parameter int HALF_DIV = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            is_read,
  input  spiu_pkg::lane_e lanes,
  input  logic [7:0]      tx_byte,
  output logic            busy,
  output logic            done,
  output logic [7:0]      rx_byte,
  output logic            sclk,
  output logic [3:0]      io_out,
  output logic [3:0]      io_oe,
  input  logic [3:0]      io_in
);
  import spiu_pkg::*;

  localparam int CNT_W = $clog2(HALF_DIV) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

  logic             busy_q, done_q, sclk_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       step_q;
  logic [7:0]       sreg_q, rx_q;
  lane_e            lanes_q;
  logic [7:0]       rx_next, sreg_next;

  always_comb begin
    case (lanes_q)
      LANE4: begin
        rx_next   = {rx_q[3:0], io_in};
        sreg_next = {sreg_q[3:0], 4'b0};
        io_out    = sreg_q[7:4];
        io_oe     = 4'b1111;
      end
      LANE2: begin
        rx_next   = {rx_q[5:0], io_in[1:0]};
        sreg_next = {sreg_q[5:0], 2'b0};
        io_out    = {2'b0, sreg_q[7:6]};
        io_oe     = 4'b0011;
      end
      default: begin
        rx_next   = {rx_q[6:0], io_in[1]};
        sreg_next = {sreg_q[6:0], 1'b0};
        io_out    = {3'b0, sreg_q[7]};
        io_oe     = 4'b0001;
      end
    endcase
    if (!busy_q || rd_q) io_oe = 4'b0000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      sclk_q  <= 1'b0;
      rd_q    <= 1'b0;
      cnt_q   <= '0;
      step_q  <= '0;
      sreg_q  <= '0;
      rx_q    <= '0;
      lanes_q <= LANE1;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          sclk_q  <= 1'b0;
          cnt_q   <= '0;
          sreg_q  <= tx_byte;
          rd_q    <= is_read;
          lanes_q <= lanes;
          step_q  <= steps_of(lanes);
        end
      end else if (cnt_q == LAST) begin
        cnt_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= rx_next;
        end else begin
          sclk_q <= 1'b0;
          sreg_q <= sreg_next;
          step_q <= step_q - 4'd1;
          if (step_q == 4'd1) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rx_q;
  assign sclk    = sclk_q;

  // R5: the serial clock rests low outside a byte.
  a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sclk_q);

  // R5: a rising serial edge only happens inside a byte.
  a_r5_rise_in_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> busy_q);

  // R5: driven data holds still across the high phase.
  a_r5_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && sclk_q && $past(sclk_q)) |-> $stable(io_out));

  // R4: completion is flagged with the clock back low and the engine idle.
  a_r4_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!sclk_q && !busy_q));

endmodule

// File: rtl/spi_user_engine.sv
module spi_user_engine #(
  parameter int NCS      = 3,
  parameter int ADDR_W   = 8,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_rdata,
  output logic              spi_sclk,
  output logic [NCS-1:0]    spi_cs_n,
  output logic [3:0]        spi_io_out,
  output logic [3:0]        spi_io_oe,
  input  logic [3:0]        spi_io_in
);
  import spiu_pkg::*;

  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1;
  localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(64);

  logic            win_hit, win_active, pend_q;
  logic [CSW-1:0]  win_idx;
  logic [31:0]     reg_rdata;
  lane_e           lanes_a [NCS];
  logic            sh_start, sh_busy, sh_done;
  logic [7:0]      sh_rx;

  always_comb begin
    win_hit = 1'b0;
    win_idx = '0;
    for (int i = 0; i < NCS; i++)
      if (req_addr == WIN_BASE + ADDR_W'(4 * i)) begin
        win_hit = 1'b1;
        win_idx = CSW'(i);
      end
  end

  assign win_active = win_hit && !spi_cs_n[win_idx];

  spiu_regs #(.NCS(NCS), .ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (req_valid && req_write && !win_hit),
    .addr  (req_addr),
    .wdata (req_wdata),
    .rdata (reg_rdata),
    .lanes (lanes_a),
    .cs_n  (spi_cs_n)
  );

  assign sh_start = req_valid && win_active && !pend_q;

  spiu_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (sh_start),
    .is_read (!req_write),
    .lanes   (lanes_a[win_idx]),
    .tx_byte (req_wdata[7:0]),
    .busy    (sh_busy),
    .done    (sh_done),
    .rx_byte (sh_rx),
    .sclk    (spi_sclk),
    .io_out  (spi_io_out),
    .io_oe   (spi_io_oe),
    .io_in   (spi_io_in)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (sh_start) pend_q <= 1'b1;
    else if (sh_done)  pend_q <= 1'b0;
  end

  assign req_ready = win_active ? sh_done : 1'b1;

  always_comb begin
    if (!win_hit)         rsp_rdata = reg_rdata;
    else if (!win_active) rsp_rdata = '0;
    else                  rsp_rdata = {24'b0, sh_rx};
  end

  // R4: an active window access stays stalled until the byte completes.
  a_r4_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && win_active && pend_q && !sh_done) |-> !req_ready);

  // R9: an inactive window is answered at once with no bus activity.
  a_r9_inactive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && win_hit && !win_active) |-> (req_ready && !sh_busy && !spi_sclk));

endmodule

// File: tb/tb_spi_user_engine.sv
module tb_spi_user_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NCS  = 3;
  localparam int AW   = 8;
  localparam int HALF = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready;
  logic [31:0] rsp_rdata;
  logic spi_sclk;
  logic [NCS-1:0] spi_cs_n;
  logic [3:0] spi_io_out, spi_io_oe, spi_io_in;

  spi_user_engine #(.NCS(NCS), .ADDR_W(AW), .HALF_DIV(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe), .spi_io_in(spi_io_in));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int nchk = 0, nfail = 0;
  int rises = 0, base = 0, lanes_b = 1, oe_bad = 0;
  logic [3:0] exp_oe = 4'b0;
  logic [7:0] cap = '0, dev_byte = '0;
  logic [15:0] shv;

  // Flash-side model: capture driven bits, present read bits MSB first.
  always @(posedge spi_sclk) begin
    case (lanes_b)
      1:       cap = {cap[6:0], spi_io_out[0]};
      2:       cap = {cap[5:0], spi_io_out[1:0]};
      default: cap = {cap[3:0], spi_io_out};
    endcase
    if (spi_io_oe !== exp_oe) oe_bad = oe_bad + 1;
    rises = rises + 1;
  end

  always_comb begin
    shv = {8'b0, dev_byte} << ((rises - base) * lanes_b);
    case (lanes_b)
      1:       spi_io_in = {2'b0, shv[7], 1'b0};
      2:       spi_io_in = {2'b0, shv[7:6]};
      default: spi_io_in = shv[7:4];
    endcase
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [AW-1:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    lat = 0;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      lat++;
      #1;
    end
    rd = rsp_rdata;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic reg_wr(input logic [AW-1:0] a, input logic [31:0] d);
    logic [31:0] rd; int lat;
    bus(1'b1, a, d, rd, lat);
    chk("R11 write latency", lat, 0);
  endtask

  task automatic reg_rd(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    logic [31:0] rd; int lat;
    bus(1'b0, a, 32'h0, rd, lat);
    chk(req, rd, exp);
  endtask

  // One active-window byte; checks edges, latency, lane use and data.
  task automatic win_xfer(input string req, input int cs, input logic wr, input int L,
                          input logic [7:0] b);
    logic [31:0] rd; int lat; int oe0;
    lanes_b = L;
    exp_oe = wr ? ((L == 1) ? 4'b0001 : (L == 2) ? 4'b0011 : 4'b1111) : 4'b0000;
    dev_byte = b;
    base = rises;
    oe0 = oe_bad;
    bus(wr, AW'(64 + 4 * cs), {24'hABCDEF, b}, rd, lat);
    chk({req, " R5 edges"}, rises - base, 8 / L);
    chk({req, " R4 latency"}, lat, 2 * HALF * (8 / L) + 1);
    chk({req, " R7 oe"}, oe_bad - oe0, 0);
    if (wr) chk({req, " write data"}, {24'b0, cap}, {24'b0, b});
    else    chk({req, " R8 read data"}, rd, {24'b0, b});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] rd; int lat; int r0;
    int L_of [4];
    logic [31:0] w_of [4];
    L_of[0] = 1; w_of[0] = 32'h0000_0003;
    L_of[1] = 2; w_of[1] = 32'h2000_0003;
    L_of[2] = 4; w_of[2] = 32'h4000_0003;
    L_of[3] = 4; w_of[3] = 32'h6000_0003;

    repeat (3) @(negedge clk);
    chk("R1 cs_n in reset", {29'b0, spi_cs_n}, 32'h7);
    chk("R1 sclk in reset", {31'b0, spi_sclk}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 oe after reset", {28'b0, spi_io_oe}, 0);
    for (int i = 0; i < NCS; i++) reg_rd("R1 ctrl reset", AW'(16 + 4 * i), 32'h4);
    reg_rd("R1 width reg reset", AW'(4), 0);
    reg_rd("R11 unmapped", AW'(8), 0);

    // R2 field storage
    reg_wr(AW'(24), 32'hFFFF_FFFF);
    reg_rd("R2 ctrl fields", AW'(24), 32'h6000_0007);
    chk("R3 stop holds cs high", {29'b0, spi_cs_n}, 32'h7);
    reg_wr(AW'(4), 32'hFF);
    reg_rd("R2 width reg mask", AW'(4), 32'h7);
    reg_wr(AW'(4), 32'h2);
    reg_rd("R2 width reg", AW'(4), 32'h2);

    // R3 mode/stop gating on device 2
    reg_wr(AW'(24), 32'h1);
    chk("R3 cmd-read mode", {29'b0, spi_cs_n}, 32'h7);
    reg_wr(AW'(24), 32'h2);
    chk("R3 cmd-write mode", {29'b0, spi_cs_n}, 32'h7);
    reg_wr(AW'(24), 32'h0);
    chk("R3 normal mode", {29'b0, spi_cs_n}, 32'h7);
    reg_wr(AW'(24), 32'h3);
    chk("R3 user active", {29'b0, spi_cs_n}, 32'h3);
    reg_wr(AW'(24), 32'h7);
    chk("R3 stop set", {29'b0, spi_cs_n}, 32'h7);

    // R9 inactive windows
    r0 = rises;
    bus(1'b1, AW'(64), 32'hA5, rd, lat);
    chk("R9 stopped write latency", lat, 0);
    bus(1'b0, AW'(64), 32'h0, rd, lat);
    chk("R9 stopped read data", rd, 0);
    reg_wr(AW'(24), 32'h1);
    bus(1'b0, AW'(72), 32'h0, rd, lat);
    chk("R9 non-user read latency", lat, 0);
    chk("R9 non-user read data", rd, 0);
    chk("R9 no clock edges", rises - r0, 0);
    reg_wr(AW'(24), 32'h4);

    // Sweeps on device 1 over all widths and byte values (R6, R7, R8)
    for (int m = 0; m < 4; m++) begin
      reg_wr(AW'(20), w_of[m]);
      chk("R3 sweep select", {29'b0, spi_cs_n}, 32'h5);
      for (int b = 0; b < 256; b++) begin
        win_xfer((m == 0) ? "R6 single wr" : "R7 wide wr", 1, 1'b1, L_of[m], 8'(b));
        win_xfer((m == 0) ? "R6 single rd" : "R7 wide rd", 1, 1'b0, L_of[m], 8'(b) ^ 8'h5A);
      end
      reg_wr(AW'(20), w_of[m] | 32'h4);
      chk("R3 sweep release", {29'b0, spi_cs_n}, 32'h7);
    end

    // R10 width change inside one transaction
    reg_wr(AW'(20), 32'h3);
    win_xfer("R10 opcode", 1, 1'b1, 1, 8'h6B);
    reg_wr(AW'(20), 32'h4000_0003);
    chk("R10 cs held", {29'b0, spi_cs_n}, 32'h5);
    win_xfer("R10 quad data", 1, 1'b0, 4, 8'hC3);
    reg_wr(AW'(20), 32'h4000_0007);
    chk("R10 end", {29'b0, spi_cs_n}, 32'h7);
    chk("R5 sclk idle", {31'b0, spi_sclk}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule